// File: doc/BRIEF.md
# Shared-Address Two-Way FIFO Target Port

This block is the slave side of a bus port. It places two queues, one flowing in each direction, behind a single 32-bit register location. The bus direction alone picks the queue. A bus read takes the oldest word from the outbound queue, which local logic fills. A bus write appends a word to the inbound queue, which local logic drains. Because of this, a word written over the bus can never be read back over the bus.

Each data phase gets its answer in the cycle it is presented. If the transfer can proceed, the port raises target-ready and moves one word. If it cannot, because the outbound queue is empty on a read or the inbound queue is full on a write, the port raises retry, inserts no wait states and moves nothing. A data phase marked as a burst continuation gets a disconnect and no transfer. The port also exports empty and full flags for both queues. These flags come from registered occupancy, so an access shows in them one clock after the edge that performed it.

Top module: `bdf_port`

## Requirements
- R1: A read data phase that is marked first, while the outbound queue is not empty, raises `bus_trdy` in that cycle. `bus_rdata` carries the oldest outbound word, and that word is removed at the clock edge.
- R2: A read data phase that is marked first, while `out_empty` is 1, raises `bus_retry` in that cycle with `bus_trdy` low. The outbound queue is left unchanged.
- R3: A write data phase that is marked first, while the inbound queue is not full, raises `bus_trdy` in that cycle. `bus_wdata` is appended to the inbound queue, and words leave on `in_rdata` in arrival order.
- R4: A write data phase that is marked first, while `in_full` is 1, raises `bus_retry` with `bus_trdy` low. Nothing is stored.
- R5: A data phase with `bus_first` = 0 (a burst continuation) raises `bus_disc` and transfers nothing, whatever the queue state.
- R6: A bus write never alters the outbound queue, and a bus read never alters the inbound queue. `bus_rdata` is 0 unless a read is acknowledged, so written data never appears on it.
- R7: `out_empty`, `out_full`, `in_empty` and `in_full` reflect occupancy as registered at the last clock edge. They change one clock after the access that altered the queue.
- R8: While `bus_sel` is 1, exactly one of `bus_trdy`, `bus_retry` and `bus_disc` is 1. While `bus_sel` is 0, all three are 0.
- R9: On the local side, `out_push` is ignored while `out_full` is 1 and `in_pop` is ignored while `in_empty` is 1. `in_rdata` shows the oldest inbound word while the queue is not empty.
- R10: After synchronous reset, both queues are empty (`out_empty` = `in_empty` = 1, `out_full` = `in_full` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | A data phase to the port is presented this cycle |
| bus_write | input | 1 | 1 = write (inbound), 0 = read (outbound) |
| bus_first | input | 1 | 1 = first data phase of the transaction, 0 = burst continuation |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid with an acknowledged read, else 0 |
| bus_trdy | output | 1 | Data phase completed |
| bus_retry | output | 1 | Disconnect with retry, no data moved |
| bus_disc | output | 1 | Disconnect of a burst continuation, no data moved |
| out_push | input | 1 | Local side appends to the outbound queue |
| out_wdata | input | 32 | Word for the outbound queue |
| out_empty | output | 1 | Outbound queue empty |
| out_full | output | 1 | Outbound queue full |
| in_pop | input | 1 | Local side removes the inbound head |
| in_rdata | output | 32 | Inbound queue head |
| in_empty | output | 1 | Inbound queue empty |
| in_full | output | 1 | Inbound queue full |

## Verification
The assertions watch every cycle for the following: the single-answer rule, retry on an empty read or a full write, disconnect of every continuation phase, unchanged flags after a refused phase, a write leaving the outbound flags alone, and the flag movement one clock after a completed transfer. Data order, the absence of lost or duplicated words across retries and disconnects, and the refusal to echo written data can only be shown by the bench. Its queue model follows every word from one side of the port to the other.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_DISC  = 2'd3
    } rsp_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              first;
        logic [WORD_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic push_in;
        logic pop_out;
    } fifo_op_t;

    // Decide the answer to one data phase from the registered queue state.
    function automatic rsp_e pick_rsp(bus_req_t req, logic out_is_empty, logic in_is_full);
        rsp_e r;
        if (!req.valid)
            r = RSP_NONE;
        else if (!req.first)
            r = RSP_DISC;
        else if (req.write)
            r = in_is_full ? RSP_RETRY : RSP_ACK;
        else
            r = out_is_empty ? RSP_RETRY : RSP_ACK;
        return r;
    endfunction

endpackage

// File: rtl/bdf_fifo.sv
module bdf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/bdf_target_ctl.sv
module bdf_target_ctl
    import bdf_pkg::*;
(
    input  bus_req_t req,
    input  logic     out_is_empty,
    input  logic     in_is_full,
    output rsp_e     rsp,
    output fifo_op_t op
);
    always_comb begin
        rsp        = pick_rsp(req, out_is_empty, in_is_full);
        op.push_in = (rsp == RSP_ACK) && req.write;
        op.pop_out = (rsp == RSP_ACK) && !req.write;
    end
endmodule

// File: rtl/bdf_port.sv
module bdf_port
    import bdf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic              bus_first,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_trdy,
    output logic              bus_retry,
    output logic              bus_disc,
    input  logic              out_push,
    input  logic [WORD_W-1:0] out_wdata,
    output logic              out_empty,
    output logic              out_full,
    input  logic              in_pop,
    output logic [WORD_W-1:0] in_rdata,
    output logic              in_empty,
    output logic              in_full
);
    bus_req_t          req;
    rsp_e              rsp;
    fifo_op_t          op;
    logic [WORD_W-1:0] out_head;

    assign req = '{valid: bus_sel, write: bus_write, first: bus_first, data: bus_wdata};

    bdf_target_ctl u_ctl (
        .req          (req),
        .out_is_empty (out_empty),
        .in_is_full   (in_full),
        .rsp          (rsp),
        .op           (op)
    );

    // Outbound: filled locally, drained by bus reads.
    bdf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_out_q (
        .clk   (clk),
        .rst   (rst),
        .push  (out_push),
        .wdata (out_wdata),
        .pop   (op.pop_out),
        .rdata (out_head),
        .empty (out_empty),
        .full  (out_full)
    );

    // Inbound: filled by bus writes, drained locally.
    bdf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_in_q (
        .clk   (clk),
        .rst   (rst),
        .push  (op.push_in),
        .wdata (req.data),
        .pop   (in_pop),
        .rdata (in_rdata),
        .empty (in_empty),
        .full  (in_full)
    );

    assign bus_trdy  = (rsp == RSP_ACK);
    assign bus_retry = (rsp == RSP_RETRY);
    assign bus_disc  = (rsp == RSP_DISC);
    assign bus_rdata = op.pop_out ? out_head : '0;
endmodule

// File: rtl/bdf_port_chk.sv
module bdf_port_chk (
    input logic clk,
    input logic rst,
    input logic bus_sel,
    input logic bus_write,
    input logic bus_first,
    input logic bus_trdy,
    input logic bus_retry,
    input logic bus_disc,
    input logic out_push,
    input logic out_empty,
    input logic out_full,
    input logic in_pop,
    input logic in_empty,
    input logic in_full
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $countones({bus_trdy, bus_retry, bus_disc}) == (bus_sel ? 1 : 0)); // R8

    AST_EMPTY_READ_RETRY: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_first && !bus_write && out_empty) |-> (bus_retry && !bus_trdy)); // R2

    AST_FULL_WRITE_RETRY: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_first && bus_write && in_full) |-> (bus_retry && !bus_trdy)); // R4

    AST_BURST_DISC: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_first) |-> bus_disc); // R5

    AST_REFUSED_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        ((bus_retry || bus_disc) && !out_push && !in_pop)
        |=> $stable({out_empty, out_full, in_empty, in_full})); // R2

    AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_write && !out_push) |=> $stable({out_empty, out_full})); // R6

    AST_ACK_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (bus_trdy && bus_write) |=> !in_empty); // R7

    AST_ACK_READ_FREES: assert property (@(posedge clk) disable iff (rst)
        (bus_trdy && !bus_write) |=> !out_full); // R7
endmodule

bind bdf_port bdf_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_first (bus_first),
    .bus_trdy  (bus_trdy),
    .bus_retry (bus_retry),
    .bus_disc  (bus_disc),
    .out_push  (out_push),
    .out_empty (out_empty),
    .out_full  (out_full),
    .in_pop    (in_pop),
    .in_empty  (in_empty),
    .in_full   (in_full)
);

// File: tb/tb_bdf_port.sv
module tb_bdf_port;
    localparam int D = 4;
    localparam int WATCHDOG_NS = 400000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_write = 1'b0, bus_first = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_trdy, bus_retry, bus_disc;
    logic        out_push = 1'b0;
    logic [31:0] out_wdata = '0;
    logic        out_empty, out_full;
    logic        in_pop = 1'b0;
    logic [31:0] in_rdata;
    logic        in_empty, in_full;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int unsigned q_out[$];
    int unsigned q_in[$];

    always #2 clk = ~clk;

    bdf_port #(.DEPTH(D)) dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_first(bus_first),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_trdy(bus_trdy), .bus_retry(bus_retry), .bus_disc(bus_disc),
        .out_push(out_push), .out_wdata(out_wdata),
        .out_empty(out_empty), .out_full(out_full),
        .in_pop(in_pop), .in_rdata(in_rdata),
        .in_empty(in_empty), .in_full(in_full)
    );

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, compare just after, advance model at the edge.
    task automatic cycle(input bit sel, input bit wr, input bit first, input int unsigned wd,
                         input bit lpush, input int unsigned lwd, input bit lpop);
        bit exp_trdy, exp_retry, exp_disc;
        int unsigned exp_rd;
        string tag;
        bus_sel = sel; bus_write = wr; bus_first = first; bus_wdata = wd;
        out_push = lpush; out_wdata = lwd; in_pop = lpop;
        #1;
        exp_trdy = 0; exp_retry = 0; exp_disc = 0; exp_rd = 0; tag = "R8";
        if (sel) begin
            if (!first) begin exp_disc = 1; tag = "R5"; end
            else if (wr) begin
                if (q_in.size() == D) begin exp_retry = 1; tag = "R4"; end
                else begin exp_trdy = 1; tag = "R3"; end
            end else begin
                if (q_out.size() == 0) begin exp_retry = 1; tag = "R2"; end
                else begin exp_trdy = 1; tag = "R1"; exp_rd = q_out[0]; end
            end
        end
        chk({bus_trdy, bus_retry, bus_disc} == {exp_trdy, exp_retry, exp_disc}, tag,
            {bus_trdy, bus_retry, bus_disc}, {exp_trdy, exp_retry, exp_disc});
        chk(bus_rdata == exp_rd, (exp_trdy && !wr) ? "R1" : "R6", bus_rdata, exp_rd);
        chk(out_empty == (q_out.size() == 0), "R7", out_empty, q_out.size() == 0);
        chk(out_full  == (q_out.size() == D), "R7", out_full, q_out.size() == D);
        chk(in_empty  == (q_in.size() == 0), "R7", in_empty, q_in.size() == 0);
        chk(in_full   == (q_in.size() == D), "R7", in_full, q_in.size() == D);
        if (q_in.size() > 0)
            chk(in_rdata == q_in[0], "R9", in_rdata, q_in[0]);
        // model update using pre-edge occupancy
        begin
            bit do_rd, do_wr, do_lp, do_lpop;
            do_rd   = exp_trdy && !wr;
            do_wr   = exp_trdy && wr;
            do_lp   = lpush && (q_out.size() < D);
            do_lpop = lpop && (q_in.size() > 0);
            if (do_rd)   void'(q_out.pop_front());
            if (do_lpop) void'(q_in.pop_front());
            if (do_lp)   q_out.push_back(lwd);
            if (do_wr)   q_in.push_back(wd);
        end
        @(negedge clk);
    endtask

    initial begin
        #WATCHDOG_NS;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        #1;
        chk(out_empty && in_empty && !out_full && !in_full, "R10",
            {out_empty, in_empty, out_full, in_full}, 4'b1100);
        chk(!bus_trdy && !bus_retry && !bus_disc, "R10", {bus_trdy, bus_retry, bus_disc}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: read empty outbound, repeated
        cycle(1, 0, 1, 0, 0, 0, 0);
        cycle(1, 0, 1, 0, 0, 0, 0);
        // R3/R4: fill inbound, then a refused write
        for (int i = 0; i < D; i++) cycle(1, 1, 1, 32'hA000_0000 + i, 0, 0, 0);
        cycle(1, 1, 1, 32'hBAD0_0001, 0, 0, 0);
        cycle(1, 1, 1, 32'hBAD0_0002, 0, 0, 0);
        // R6: read after writes must retry, not echo
        cycle(1, 0, 1, 0, 0, 0, 0);
        // R5: continuation phases on both directions
        cycle(1, 1, 0, 32'hBAD0_0003, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);
        // R9: drain inbound in order, extra pops ignored
        for (int i = 0; i < D + 2; i++) cycle(0, 0, 1, 0, 0, 0, 1);
        // R9: fill outbound past full
        for (int i = 0; i < D + 2; i++) cycle(0, 0, 1, 0, 1, 32'hC000_0000 + i, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);                  // R5 with data present
        for (int i = 0; i < D; i++) cycle(1, 0, 1, 0, 0, 0, 0); // R1
        cycle(1, 0, 1, 0, 0, 0, 0);                  // R2 again
        // simultaneous local push and bus read, write and local pop
        cycle(0, 0, 1, 0, 1, 32'h1111, 0);
        cycle(1, 0, 1, 0, 1, 32'h2222, 0);
        cycle(1, 1, 1, 32'h3333, 0, 0, 1);
        cycle(1, 1, 1, 32'h4444, 1, 32'h5555, 1);
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            cycle(r[0], r[1], (r[4:2] != 0), $urandom, r[5], $urandom, r[6]);
        end
        cycle(0, 0, 1, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule